// File: doc/BRIEF.md
# Timed Pulse Command Sequencer

This block runs a stream of 64-bit command words that arrive over a valid/ready handshake. It takes one word at a time, in arrival order, and drives a single digital output line. Every word holds an operation code in its upper bits and an operand in its lower bits. There are three operations. One drives the line high and one drives it low. The third holds the sequencer for a number of microseconds, and that number comes from the word's own operand. Because each hold word carries its own length, a host can build pulses and gaps of any width without repeating a fixed delay step.

The microsecond timebase comes from the system clock through the parameter `CLKS_PER_US`. A run-enable input gates the acceptance of new words. A busy flag shows that a hold is still counting. A sticky error flag records any word whose operation code has no meaning.

Top module: `pulse_cmd_seq`

## Requirements
- R1: Bits 63:54 of a word are the opcode and bits 53:0 are the operand. An accepted opcode 1 makes `pulse_out` high from the accepting clock edge onward. An accepted opcode 3 makes it low. For both opcodes the operand has no effect.
- R2: Opcode 2 is a hold. The operand N is an unsigned count of microseconds. The word after the hold is accepted exactly N*CLKS_PER_US cycles after the hold's accepting edge. `pulse_out` does not change during the hold.
- R3: Words run strictly in arrival order, and each word uses only its own operand. When words are streamed back-to-back with CLKS_PER_US=40, the sequence high / hold 1 / low gives a high time of 41 cycles, which is 40 cycles of hold plus the accept cycle of the low word. Appending hold 1 / high / hold 2 / low then gives a 41-cycle low gap followed by an 81-cycle high pulse.
- R4: A hold with operand 0 takes only its accept cycle. The next word can be accepted on the following edge, `busy` stays low, and `pulse_out` is unchanged.
- R5: `cmd_ready` is high only while `run_en` is high and no hold is counting. A word offered while `cmd_ready` is low is not consumed and has no effect on the outputs.
- R6: Opcode 0 and every opcode above 3 act as no-operations. `pulse_out` does not change, and `err_flag` goes high and stays high until reset.
- R7: `busy` is high in every cycle in which a hold is still counting. This runs from the cycle after the accept edge of a hold with N*CLKS_PER_US > 1 up to the hold's last cycle. `busy` is low at all other times.
- R8: An active-low `rst_n` drives `pulse_out` low, clears `err_flag` and `busy`, and abandons any hold that is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows new words to be accepted |
| cmd_valid | input | 1 | A command word is offered |
| cmd_word | input | 64 | Command word: opcode in 63:54, operand in 53:0 |
| cmd_ready | output | 1 | The sequencer takes the word at this edge |
| pulse_out | output | 1 | Digital output line |
| busy | output | 1 | A hold is counting |
| err_flag | output | 1 | Sticky flag for unknown opcodes |

## Verification
The bench targets the accept spacing after a hold. A timer that is off by one cycle makes every measured pulse width wrong by one per hold, and the widths 41 and 81 show this at once. It also sends a zero-length hold, which a design that underflows its counter turns into an enormous stall. It sends set words with junk operands, which an operand-sensitive decoder would mishandle. It offers words while `run_en` is low, which a design that consumes them early would act on. Finally it resets in the middle of a very long hold, where a design that does not clear the timer would stay busy.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
    localparam int OPC_W = 10;
    localparam int ARG_W = 54;
    localparam int WORD_W = OPC_W + ARG_W;

    localparam logic [OPC_W-1:0] OPC_SET_HI = OPC_W'(1);
    localparam logic [OPC_W-1:0] OPC_HOLD   = OPC_W'(2);
    localparam logic [OPC_W-1:0] OPC_SET_LO = OPC_W'(3);

    typedef struct packed {
        logic set_hi;
        logic set_lo;
        logic hold;
        logic bad;
    } op_class_t;

    typedef struct packed {
        logic line;
        logic err;
    } seq_state_t;
endpackage

// File: rtl/pseq_decode.sv
module pseq_decode
    import pseq_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output op_class_t        cls_o
);
    always_comb begin
        cls_o = '0;
        unique case (opc_i)
            OPC_SET_HI: cls_o.set_hi = 1'b1;
            OPC_SET_LO: cls_o.set_lo = 1'b1;
            OPC_HOLD:   cls_o.hold   = 1'b1;
            default:    cls_o.bad    = 1'b1;
        endcase
    end
endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
    parameter int ARG_W       = 54,
    parameter int CLKS_PER_US = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ARG_W-1:0] arg_i,
    output logic             busy_o
);
    localparam int MUL_W = $clog2(CLKS_PER_US + 1);
    localparam int CNT_W = ARG_W + MUL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] span;

    always_comb begin
        span  = CNT_W'(arg_i) * CNT_W'(CLKS_PER_US);
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = (span == '0) ? '0 : span - 1'b1;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = (tmr_q.cnt != '0);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> tmr_q.cnt == $past(tmr_q.cnt) - 1'b1);

    // R5
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);
endmodule

// File: rtl/pulse_cmd_seq.sv
module pulse_cmd_seq
    import pseq_pkg::*;
#(
    parameter int CLKS_PER_US = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              cmd_ready,
    output logic              pulse_out,
    output logic              busy,
    output logic              err_flag
);
    localparam bit MULTI_CYCLE_US = (CLKS_PER_US > 1);

    logic [OPC_W-1:0] opc;
    logic [ARG_W-1:0] arg;
    op_class_t        cls;
    logic             take;
    logic             tmr_busy;
    seq_state_t       st_d, st_q;

    assign opc = cmd_word[WORD_W-1 -: OPC_W];
    assign arg = cmd_word[ARG_W-1:0];

    pseq_decode u_dec (
        .opc_i (opc),
        .cls_o (cls)
    );

    assign cmd_ready = run_en && !tmr_busy;
    assign take      = cmd_valid && cmd_ready;

    pseq_timer #(
        .ARG_W       (ARG_W),
        .CLKS_PER_US (CLKS_PER_US)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take && cls.hold),
        .arg_i  (arg),
        .busy_o (tmr_busy)
    );

    always_comb begin
        st_d = st_q;
        if (take) begin
            if (cls.set_hi) st_d.line = 1'b1;
            if (cls.set_lo) st_d.line = 1'b0;
            if (cls.bad)    st_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_out = st_q.line;
    assign err_flag  = st_q.err;
    assign busy      = tmr_busy;

    // R1
    line_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse_out) |-> $past(cmd_valid && cmd_ready));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R5
    no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);

    // R2
    hold_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pulse_out));

    // R7
    busy_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls.hold && arg != '0 && MULTI_CYCLE_US) |=> busy);
endmodule

// File: tb/pulse_cmd_seq_bench.sv
module pulse_cmd_seq_bench;
    localparam int C = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic cmd_valid = 1'b0;
    logic [63:0] cmd_word = '0;
    logic cmd_ready, pulse_out, busy, err_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pulse_cmd_seq #(.CLKS_PER_US(C)) u_pulse_cmd_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .cmd_ready(cmd_ready), .pulse_out(pulse_out),
        .busy(busy), .err_flag(err_flag)
    );

    // behavioural reference model
    bit     m_line = 0;
    bit     m_err  = 0;
    longint m_rem  = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_line = 0; m_err = 0; m_rem = 0;
        end else if (cmd_valid && run_en && m_rem == 0) begin
            case (int'(cmd_word[63:54]))
                1: m_line = 1;
                3: m_line = 0;
                2: begin
                    longint span;
                    span = longint'(cmd_word[53:0]) * C;
                    m_rem = (span == 0) ? 0 : span - 1;
                end
                default: m_err = 1;
            endcase
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lockstep comparison away from the active edge
    int run_len = 0;
    int widths[$];
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 line", pulse_out, m_line);
            chk("R6 err", err_flag, m_err);
            chk("R7 busy", busy, m_rem > 0);
            chk("R5 ready", cmd_ready, run_en && m_rem == 0);
            if (pulse_out) run_len++;
            else if (run_len > 0) begin widths.push_back(run_len); run_len = 0; end
        end else run_len = 0;
    end

    function automatic logic [63:0] mk(input int op, input longint a);
        return {10'(op), 54'(a)};
    endfunction

    task automatic send(input logic [63:0] w);
        cmd_valid = 1'b1; cmd_word = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 line at reset", pulse_out, 0);
        chk("R8 busy at reset", busy, 0);
        chk("R8 err at reset", err_flag, 0);
        rst_n = 1'b1; run_en = 1'b1;
        @(negedge clk);

        // R3 single pulse; R1 operand ignored on set words
        send(mk(1, 54'h3FF_FFFF)); send(mk(2, 1)); send(mk(3, 12345));
        repeat (3) @(negedge clk);
        chk("R3 first width", widths.size() > 0 ? widths[0] : -1, 41);

        // R3 chained pulses of different widths, R2 spacing
        widths.delete();
        send(mk(1, 0)); send(mk(2, 1)); send(mk(3, 0));
        send(mk(2, 1)); send(mk(1, 0)); send(mk(2, 2)); send(mk(3, 0));
        repeat (3) @(negedge clk);
        chk("R3 chain count", widths.size(), 2);
        chk("R3 chain w0", widths.size() > 0 ? widths[0] : -1, 41);
        chk("R2 chain w1", widths.size() > 1 ? widths[1] : -1, 81);

        // R4 zero-length hold
        send(mk(2, 0));
        chk("R4 busy after zero hold", busy, 0);
        chk("R4 ready after zero hold", cmd_ready, 1);

        // R6 unknown opcodes
        send(mk(1, 0));
        send(mk(0, 7));
        chk("R6 line after op0", pulse_out, 1);
        chk("R6 err after op0", err_flag, 1);
        send(mk(1023, 1));
        send(mk(5, 1));
        send(mk(3, 0));
        chk("R6 err still set", err_flag, 1);
        chk("R1 line low", pulse_out, 0);

        // R5 run_en low: word not consumed
        run_en = 1'b0;
        cmd_valid = 1'b1; cmd_word = mk(1, 0);
        repeat (5) @(negedge clk);
        chk("R5 ready low", cmd_ready, 0);
        chk("R5 word not taken", pulse_out, 0);
        run_en = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R5 word taken after enable", pulse_out, 1);

        // R7/R8 long hold abandoned by reset
        send(mk(2, 64'd1 << 40));
        repeat (10) @(negedge clk);
        chk("R7 busy in long hold", busy, 1);
        chk("R5 ready low in hold", cmd_ready, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 busy cleared", busy, 0);
        chk("R8 line cleared", pulse_out, 0);
        chk("R8 err cleared", err_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 ready after reset", cmd_ready, 1);
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule